// File: doc/BRIEF.md
# Clock Target Compare Output

This block watches a free-running 64-bit precision-time counter and compares it with a 64-bit target value that software loads. Software loads the target as two 32-bit words. When the counter reaches the target, the block sets a sticky target interrupt flag. On the same event, each of its GPIO outputs reacts in its own mode: a fixed-width pulse, a level toggle, or a copy of the flag.

Each pin has a polarity bit that picks active-high or active-low drive. Each pin also has an override bit that makes the pin an output whatever its ordinary direction bit says. The block does not touch the pin's buffer type (push-pull or open-drain), which stays under ordinary GPIO control. The time counter itself is generated elsewhere.

Top module: `clk_target_out`

## Requirements
- R1: A high-word write only stages the value. The 64-bit target changes only on a low-word write, and then becomes {staged high word, written low word}. A staged high word alone never produces a match.
- R2: A compare event is the first cycle in which `time_now` equals the target after a cycle in which they differed. On an event, `tgt_flag` reads 1 from the next cycle.
- R3: `tgt_flag` stays set until `flag_clr_sw` is high, or a `gpio_clr_req` bit whose `gpio_clr_en` bit is 1 is high. A clear takes effect from the next cycle, and a compare event in the same cycle wins over a clear.
- R4: A `gpio_clr_req` bit whose `gpio_clr_en` bit is 0 has no effect on `tgt_flag`.
- R5: Mode code 0 (pulse) makes the pin active for exactly PULSE_CYCLES (default 10, i.e. 100 ns at 100 MHz) cycles, starting in the cycle after the event.
- R6: In pulse mode, an event that occurs while a pulse is running restarts the full PULSE_CYCLES count.
- R7: Mode code 1 (toggle) inverts the pin's internal active state on every event and holds it otherwise.
- R8: Mode code 2 makes the pin active exactly while `tgt_flag` is 1. Mode code 3 holds the pin inactive.
- R9: Polarity bit 1 drives the active state as a 1 on `pin_out`. Polarity bit 0 drives the active state as a 0.
- R10: `pin_oe` of a pin is 1 when its override bit or its direction bit is 1.
- R11: After reset, `tgt_flag` is 0, every internal active state is inactive, and the target holds all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current precision-time value |
| tgt_hi_wr | input | 1 | Stage `tgt_wdata` as target high word |
| tgt_lo_wr | input | 1 | Commit target with `tgt_wdata` as low word |
| tgt_wdata | input | 32 | Target write data |
| pin_mode | input | 4 | Two bits per pin: 0 pulse, 1 toggle, 2 flag, 3 off |
| pin_pol | input | 2 | Per-pin polarity, 1 = active high |
| ovr_oe | input | 2 | Per-pin output-enable override |
| gpio_dir | input | 2 | Per-pin ordinary direction bit, 1 = output |
| flag_clr_sw | input | 1 | Software clear of the target flag |
| gpio_clr_req | input | 2 | Qualified GPIO input clear requests |
| gpio_clr_en | input | 2 | Per-pin enable for the GPIO clear |
| pin_out | output | 2 | Pin output levels |
| pin_oe | output | 2 | Pin output enables |
| tgt_flag | output | 1 | Sticky target interrupt flag |

## Verification
The bench stages a high word and then presents a time equal to {new high, old low}. A design that compared against the staged word would set the flag there. It fires a second event halfway through a pulse; a design that ignores restarts would end the pulse early. It also raises a clear in the same cycle as an event. A design where the clear wins would drop an interrupt. Random traffic holds the time on the target for several cycles, which catches a design that re-triggers on a level instead of an edge, and it changes modes, polarities and clear enables against a bench model.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  typedef enum logic [1:0] {
    MODE_PULSE  = 2'd0,
    MODE_TOGGLE = 2'd1,
    MODE_FLAG   = 2'd2,
    MODE_OFF    = 2'd3
  } out_mode_e;

  // Active state to pin level: pol=1 drives active as 1.
  function automatic logic drive_level(input logic active, input logic pol);
    return pol ? active : ~active;
  endfunction

  // Next pulse count: reload on event, else count down to zero.
  function automatic int unsigned pulse_next(input int unsigned cur,
                                             input logic evt,
                                             input int unsigned len);
    if (evt) return len;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/ctc_target_reg.sv
module ctc_target_reg #(
  parameter int WORD_W = 32,
  localparam int TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [TIME_W-1:0] target
);

  logic [WORD_W-1:0] hi_stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage <= '1;
      target   <= '1;
    end else begin
      if (hi_wr) hi_stage <= wdata;
      if (lo_wr) target   <= {hi_stage, wdata};
    end
  end

  assert_hi_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !lo_wr) |=> $stable(target));

endmodule

// File: rtl/ctc_match.sv
module ctc_match #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic [TIME_W-1:0] target,
  output logic              evt
);

  logic hit, hit_d;

  assign hit = (time_now == target);
  assign evt = hit && !hit_d;

  always_ff @(posedge clk) begin
    if (!rst_n) hit_d <= 1'b0;
    else        hit_d <= hit;
  end

  assert_single_evt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

endmodule

// File: rtl/ctc_pin_drv.sv
module ctc_pin_drv
  import ctc_pkg::*;
#(
  parameter int PULSE_CYCLES = 10,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic       flag,
  input  logic [1:0] mode,
  input  logic       pol,
  output logic       level
);

  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic             active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tog <= 1'b0;
    end else begin
      cnt <= CNT_W'(pulse_next(int'(cnt), evt, PULSE_CYCLES));
      tog <= tog ^ evt;
    end
  end

  always_comb begin
    case (mode)
      MODE_PULSE:  active = (cnt != '0);
      MODE_TOGGLE: active = tog;
      MODE_FLAG:   active = flag;
      default:     active = 1'b0;
    endcase
  end

  assign level = drive_level(active, pol);

  assert_pulse_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cnt == CNT_W'(PULSE_CYCLES)));
  assert_pulse_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (tog != $past(tog)));
  assert_toggle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(tog));

endmodule

// File: rtl/clk_target_out.sv
module clk_target_out
  import ctc_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int NUM_PINS     = 2,
  parameter int PULSE_CYCLES = 10,
  localparam int TIME_W = 2 * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TIME_W-1:0]     time_now,
  input  logic                  tgt_hi_wr,
  input  logic                  tgt_lo_wr,
  input  logic [WORD_W-1:0]     tgt_wdata,
  input  logic [2*NUM_PINS-1:0] pin_mode,
  input  logic [NUM_PINS-1:0]   pin_pol,
  input  logic [NUM_PINS-1:0]   ovr_oe,
  input  logic [NUM_PINS-1:0]   gpio_dir,
  input  logic                  flag_clr_sw,
  input  logic [NUM_PINS-1:0]   gpio_clr_req,
  input  logic [NUM_PINS-1:0]   gpio_clr_en,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic                  tgt_flag
);

  logic [TIME_W-1:0] target;
  logic              evt;
  logic              clr_any;

  ctc_target_reg #(.WORD_W(WORD_W)) u_target (
    .clk(clk), .rst_n(rst_n), .hi_wr(tgt_hi_wr), .lo_wr(tgt_lo_wr),
    .wdata(tgt_wdata), .target(target)
  );

  ctc_match #(.TIME_W(TIME_W)) u_match (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .target(target), .evt(evt)
  );

  assign clr_any = flag_clr_sw || |(gpio_clr_req & gpio_clr_en);

  always_ff @(posedge clk) begin
    if (!rst_n)       tgt_flag <= 1'b0;
    else if (evt)     tgt_flag <= 1'b1;
    else if (clr_any) tgt_flag <= 1'b0;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    ctc_pin_drv #(.PULSE_CYCLES(PULSE_CYCLES)) u_drv (
      .clk(clk), .rst_n(rst_n), .evt(evt), .flag(tgt_flag),
      .mode(pin_mode[2*p +: 2]), .pol(pin_pol[p]), .level(pin_out[p])
    );
    assign pin_oe[p] = ovr_oe[p] | gpio_dir[p];
  end

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> tgt_flag);
  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && clr_any) |=> !tgt_flag);
  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !clr_any) |=> $stable(tgt_flag));

endmodule

// File: tb/clk_target_out_tb_top.sv
module clk_target_out_tb_top;

  localparam int NP = 2;
  localparam int PC = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_now;
  logic        tgt_hi_wr, tgt_lo_wr;
  logic [31:0] tgt_wdata;
  logic [3:0]  pin_mode;
  logic [1:0]  pin_pol, ovr_oe, gpio_dir, gpio_clr_req, gpio_clr_en;
  logic        flag_clr_sw;
  logic [1:0]  pin_out, pin_oe;
  logic        tgt_flag;

  always #4 clk = ~clk;

  clk_target_out dut_i (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .tgt_hi_wr(tgt_hi_wr),
    .tgt_lo_wr(tgt_lo_wr), .tgt_wdata(tgt_wdata), .pin_mode(pin_mode),
    .pin_pol(pin_pol), .ovr_oe(ovr_oe), .gpio_dir(gpio_dir),
    .flag_clr_sw(flag_clr_sw), .gpio_clr_req(gpio_clr_req),
    .gpio_clr_en(gpio_clr_en), .pin_out(pin_out), .pin_oe(pin_oe),
    .tgt_flag(tgt_flag)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [63:0] m_target, m_stage;
  logic        m_prev_hit, m_flag;
  int          m_cnt [NP];
  logic        m_tog [NP];

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_active(input logic [1:0] mode, input int cnt,
                                      input logic tog, input logic flag);
    case (mode)
      2'd0:    return cnt > 0;
      2'd1:    return tog;
      2'd2:    return flag;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_pin(input int p);
    logic a;
    a = exp_active(pin_mode[2*p +: 2], m_cnt[p], m_tog[p], m_flag);
    return (pin_pol[p] == 1'b1) ? a : !a;
  endfunction

  function automatic string pin_tag(input int p);
    if (pin_pol[p] == 1'b0) return "R9";
    case (pin_mode[2*p +: 2])
      2'd0:    return "R5";
      2'd1:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_reset();
    m_target = '1; m_stage = '1; m_prev_hit = 1'b0; m_flag = 1'b0;
    for (int p = 0; p < NP; p++) begin m_cnt[p] = 0; m_tog[p] = 1'b0; end
  endtask

  task automatic check_all();
    chk("R3", "tgt_flag", 64'(tgt_flag), 64'(m_flag));
    for (int p = 0; p < NP; p++) begin
      chk(pin_tag(p), $sformatf("pin_out[%0d]", p), 64'(pin_out[p]), 64'(exp_pin(p)));
      chk("R10", $sformatf("pin_oe[%0d]", p), 64'(pin_oe[p]), 64'(ovr_oe[p] | gpio_dir[p]));
    end
  endtask

  task automatic step();
    logic hit, evt, clr;
    @(posedge clk);
    hit = (time_now == m_target);
    evt = hit && !m_prev_hit;
    m_prev_hit = hit;
    clr = flag_clr_sw || ((gpio_clr_req & gpio_clr_en) != 2'b00);
    if (evt) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (evt) m_cnt[p] = PC;
      else if (m_cnt[p] > 0) m_cnt[p]--;
      m_tog[p] = m_tog[p] ^ evt;
    end
    if (tgt_lo_wr) m_target = {m_stage, tgt_wdata};
    if (tgt_hi_wr) m_stage = tgt_wdata;
    @(negedge clk);
    check_all();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; time_now = 64'd0; tgt_hi_wr = 0; tgt_lo_wr = 0; tgt_wdata = '0;
    pin_mode = 4'b01_00; pin_pol = 2'b01; ovr_oe = 2'b01; gpio_dir = 2'b00;
    flag_clr_sw = 0; gpio_clr_req = 0; gpio_clr_en = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R11: reset state, pin 0 active-high idle 0, pin 1 active-low idle 1
    chk("R11", "tgt_flag", 64'(tgt_flag), 64'd0);
    chk("R11", "pin_out", 64'(pin_out), 64'b10);
    rst_n = 1'b1;
    pin_pol = 2'b11;
    // R11: target is all ones after reset
    time_now = '1;
    step();
    chk("R11", "flag on all-ones match", 64'(tgt_flag), 64'd1);
    // R4: disabled GPIO clear ignored
    time_now = 64'd0; gpio_clr_req = 2'b01; gpio_clr_en = 2'b10;
    step();
    chk("R4", "flag after disabled clear", 64'(tgt_flag), 64'd1);
    // R3: enabled GPIO clear
    gpio_clr_en = 2'b01;
    step();
    chk("R3", "flag after enabled clear", 64'(tgt_flag), 64'd0);
    gpio_clr_req = 2'b00;
    // R1: staged high word alone never matches
    tgt_hi_wr = 1; tgt_wdata = 32'h0000_000A;
    step();
    tgt_hi_wr = 0; time_now = {32'h0000_000A, 32'hFFFF_FFFF};
    step();
    chk("R1", "flag with staged high only", 64'(tgt_flag), 64'd0);
    tgt_lo_wr = 1; tgt_wdata = 32'h5; time_now = 64'd0;
    step();
    tgt_lo_wr = 0; time_now = {32'hA, 32'h5};
    step();
    chk("R2", "flag after match", 64'(tgt_flag), 64'd1);
    chk("R5", "pulse first cycle", 64'(pin_out[0]), 64'd1);
    // R2: held equality gives no second event; pulse keeps counting down
    for (int k = 2; k <= 11; k++) begin
      if (k == 4) time_now = 64'd0;
      step();
      chk("R5", $sformatf("pulse cycle %0d", k), 64'(pin_out[0]), 64'(k <= PC));
    end
    // R6: restart during pulse
    time_now = {32'hA, 32'h5};
    step();
    time_now = 64'd0;
    repeat (4) step();
    time_now = {32'hA, 32'h5};
    step();
    time_now = 64'd0;
    for (int k = 2; k <= 11; k++) begin
      step();
      chk("R6", $sformatf("restarted pulse cycle %0d", k), 64'(pin_out[0]), 64'(k <= PC));
    end
    // R3: event wins over simultaneous clear
    flag_clr_sw = 1; time_now = {32'hA, 32'h5};
    step();
    chk("R3", "event beats clear", 64'(tgt_flag), 64'd1);
    flag_clr_sw = 0;
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) time_now = {$urandom, $urandom};
      else if (r < 3) time_now = m_target;
      else if (r < 5) time_now = 64'(i);
      tgt_hi_wr = ($urandom % 12) == 0;
      tgt_lo_wr = ($urandom % 12) == 0;
      tgt_wdata = (($urandom % 2) == 0) ? $urandom : 32'($urandom % 4);
      flag_clr_sw = ($urandom % 10) == 0;
      gpio_clr_req = 2'($urandom);
      if (i % 50 == 0) gpio_clr_en = 2'($urandom);
      if (i % 37 == 0) begin pin_mode = 4'($urandom); pin_pol = 2'($urandom); end
      ovr_oe = 2'($urandom); gpio_dir = 2'($urandom);
      step();
    end
    summary();
    $finish;
  end

endmodule